// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display: horizontal and vertical sync, a composite sync, a blanking flag, a pixel-active flag and a horizontal transfer-holdoff window. Software sets every edge position by writing byte-wide registers over a simple byte bus. The registers sit at byte offsets 0x10 to 0x1F. Offsets below 0x10 are outside the block.

A horizontal unit is `PIX_PER_UNIT` clocks. A line is `H_TOTAL` units and a frame is `V_TOTAL` lines. All three are elaboration parameters. Each window is half-open, written as [start, end). It is wrap-aware: when start is greater than end, the window runs through zero. When start equals end, the window is empty. The block also raises an interrupt when vertical blank begins. A status register holds the pending flag alongside two read-only sense fields sampled from pins.

Top module: `raster_timing`

## Requirements
- R1: While reset is asserted and after its release, every register reads 0x00. `hsync`, `vsync`, `csync`, `pixelActive`, `xferHoldoff` and `irq` are low and `blank` is high.
- R2: Writes to offsets 0x10 and 0x12 to 0x1F are stored and read back unchanged on `busRdata` in the cycle after the write edge. Writes below 0x10 are ignored, and reads there return 0x00. Register layout by offset:
  - 0x10: control.
  - 0x12, 0x13: cursor start, cursor end (storage only).
  - 0x14, 0x15: hblank start, end.
  - 0x16, 0x17: hsync start, end.
  - 0x18: composite-sync end.
  - 0x19, 0x1A: vblank start, high byte and low byte.
  - 0x1B: vblank end.
  - 0x1C, 0x1D: vsync start, end.
  - 0x1E, 0x1F: transfer-holdoff start, end.
- R3: Offset 0x11 reads as follows. Bit 7 is interrupt pending. Bits 6:4 are `senseIn` and bits 3:0 are `monIdIn`, both as sampled on the previous clock edge. Writes never alter bits 6:0.
- R4: With control bit 5 (timing enable) at 0, the unit, line and frame counters are held at zero. `hsync`, `vsync`, `csync`, `xferHoldoff` and `pixelActive` are low and `blank` is high.
- R5: After the edge that sets control bit 5, the horizontal position starts at 0 and advances once every `PIX_PER_UNIT` clocks. It wraps after `H_TOTAL` units. `hsync` is high while the position lies in the hsync window.
- R6: The line count advances when the horizontal position wraps, and it wraps after `V_TOTAL` lines. Vblank runs from the line `{0x19,0x1A}` to the line in 0x1B. `vsync` is high while the line lies in the window 0x1C to 0x1D.
- R7: `blank` is high when timing is disabled, or when the horizontal position is in the hblank window, or when the line is in the vblank window.
- R8: `pixelActive` is high only when timing is on, control bit 6 is 1 and `blank` is low. Clearing bit 6 leaves the sync, blank and holdoff outputs unchanged.
- R9: `csync` equals `hsync` XOR (`vsync` AND horizontal position < register 0x18).
- R10: `xferHoldoff` is high while timing is on and the horizontal position is in the window 0x1E to 0x1F.
- R11: The pending flag (`irq`, status bit 7) sets on the edge where timing is on and the vblank window is seen active after being inactive on the previous cycle. It sets only when control bit 7 is 1, and then it stays set.
- R12: Writing 0x11 with bit 7 set clears the pending flag. Writing it with bit 7 clear has no effect. A set on the same edge wins over a clear.
- R13: With control bit 7 at 0, the pending flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Byte write strobe |
| busAddr | input | ADDR_W | Byte offset for read and write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| senseIn | input | 3 | Monitor resolution sense code pins |
| monIdIn | input | 4 | Monitor ID pins |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync |
| blank | output | 1 | Raster blanking |
| pixelActive | output | 1 | Visible pixel with video enabled |
| xferHoldoff | output | 1 | Horizontal transfer-holdoff window |
| irq | output | 1 | Vertical-blank interrupt pending |

## Verification
A baseline setup mixes window types on small line and frame sizes:
- hblank and vblank wrap through zero;
- hsync, vsync and holdoff windows do not wrap;
- the composite-sync end sits mid-line.

Together these separate the wrapping and non-wrapping comparisons, and the serrated composite sync from a plain XOR. Random rewrites then produce further window shapes:
- empty windows, where start equals end;
- out-of-range positions;
- vblank start addresses above 255.

Random control values toggle timing, video and interrupt enables at random points within the frame. Random status writes and sense-pin changes separate the read-only fields from the clearable flag. Directed sequences cover three cases:
- clear with bit 7 zero against clear with bit 7 set;
- a full frame with interrupts masked;
- out-of-map writes read back afterwards.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Register indices inside the 16-byte window (offset minus 0x10)
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_HBS   = 4;
  localparam int IDX_HBE   = 5;
  localparam int IDX_HSS   = 6;
  localparam int IDX_HSE   = 7;
  localparam int IDX_CSE   = 8;
  localparam int IDX_VBHI  = 9;
  localparam int IDX_VBLO  = 10;
  localparam int IDX_VBE   = 11;
  localparam int IDX_VSS   = 12;
  localparam int IDX_VSE   = 13;
  localparam int IDX_XHS   = 14;
  localparam int IDX_XHE   = 15;

  // Control bits
  localparam int CTRL_INT_BIT = 7;
  localparam int CTRL_VID_BIT = 6;
  localparam int CTRL_TIM_BIT = 5;

  typedef struct packed {
    logic        timingEn;
    logic        videoEn;
    logic        intEn;
    logic [7:0]  hbStart;
    logic [7:0]  hbEnd;
    logic [7:0]  hsStart;
    logic [7:0]  hsEnd;
    logic [7:0]  csEnd;
    logic [15:0] vbStart;
    logic [7:0]  vbEnd;
    logic [7:0]  vsStart;
    logic [7:0]  vsEnd;
    logic [7:0]  xhStart;
    logic [7:0]  xhEnd;
  } timingCfg_t;

  typedef struct packed {
    logic vbRise;
  } dpEvt_t;

  // Half-open window test, wrapping through zero when start exceeds end
  function automatic logic inWin(input logic [15:0] pos,
                                 input logic [15:0] winStart,
                                 input logic [15:0] winEnd);
    if (winStart <= winEnd)
      return (pos >= winStart) && (pos < winEnd);
    else
      return (pos >= winStart) || (pos < winEnd);
  endfunction

endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [2:0]        senseIn,
  input  logic [3:0]        monIdIn,
  input  dpEvt_t            evt,
  output timingCfg_t        cfg,
  output logic              irq
);

  localparam int NREG = 16;

  logic [7:0] regBank [NREG];
  logic       inMap;
  logic [3:0] regIdx;
  logic       statWr;
  logic [2:0] senseQ;
  logic [3:0] idQ;
  logic       intPend;
  logic       pendSet;

  assign inMap  = (busAddr >> 4) == ADDR_W'(1);
  assign regIdx = busAddr[3:0];
  assign statWr = busWr && inMap && (regIdx == 4'(IDX_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regBank[i] <= '0;
    end else if (busWr && inMap && (regIdx != 4'(IDX_STAT))) begin
      regBank[regIdx] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      senseQ <= '0;
      idQ    <= '0;
    end else begin
      senseQ <= senseIn;
      idQ    <= monIdIn;
    end
  end

  assign pendSet = evt.vbRise && regBank[IDX_CTRL][CTRL_INT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     intPend <= 1'b0;
    else if (pendSet)               intPend <= 1'b1;
    else if (statWr && busWdata[7]) intPend <= 1'b0;
  end

  always_comb begin
    busRdata = 8'h00;
    if (inMap) begin
      if (regIdx == 4'(IDX_STAT)) busRdata = {intPend, senseQ, idQ};
      else                        busRdata = regBank[regIdx];
    end
  end

  always_comb begin
    cfg.timingEn = regBank[IDX_CTRL][CTRL_TIM_BIT];
    cfg.videoEn  = regBank[IDX_CTRL][CTRL_VID_BIT];
    cfg.intEn    = regBank[IDX_CTRL][CTRL_INT_BIT];
    cfg.hbStart  = regBank[IDX_HBS];
    cfg.hbEnd    = regBank[IDX_HBE];
    cfg.hsStart  = regBank[IDX_HSS];
    cfg.hsEnd    = regBank[IDX_HSE];
    cfg.csEnd    = regBank[IDX_CSE];
    cfg.vbStart  = {regBank[IDX_VBHI], regBank[IDX_VBLO]};
    cfg.vbEnd    = regBank[IDX_VBE];
    cfg.vsStart  = regBank[IDX_VSS];
    cfg.vsEnd    = regBank[IDX_VSE];
    cfg.xhStart  = regBank[IDX_XHS];
    cfg.xhEnd    = regBank[IDX_XHE];
  end

  assign irq = intPend;

endmodule

// File: rtl/raster_dp.sv
module raster_dp
  import raster_pkg::*;
#(
  parameter int PIX_PER_UNIT = 8,
  parameter int H_TOTAL      = 200,
  parameter int V_TOTAL      = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  timingCfg_t cfg,
  output dpEvt_t     evt,
  output logic       hsync,
  output logic       vsync,
  output logic       csync,
  output logic       blank,
  output logic       pixelActive,
  output logic       xferHoldoff
);

  localparam int H_W = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1;
  localparam int V_W = (V_TOTAL > 1) ? $clog2(V_TOTAL) : 1;

  logic           unitTick;
  logic           lineEnd;
  logic [H_W-1:0] hCnt;
  logic [V_W-1:0] vCnt;
  logic [15:0]    hPos;
  logic [15:0]    vPos;
  logic           hbWin, hsWin, vbWin, vsWin, xhWin;
  logic           vbQ;
  logic           en;

  assign en = cfg.timingEn;

  generate
    if (PIX_PER_UNIT > 1) begin : g_pre
      localparam int PS_W = $clog2(PIX_PER_UNIT);
      logic [PS_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  preCnt <= '0;
        else if (!en)                                preCnt <= '0;
        else if (preCnt == PS_W'(PIX_PER_UNIT - 1))  preCnt <= '0;
        else                                         preCnt <= preCnt + 1'b1;
      end
      assign unitTick = en && (preCnt == PS_W'(PIX_PER_UNIT - 1));
    end else begin : g_nopre
      assign unitTick = en;
    end
  endgenerate

  assign lineEnd = unitTick && (hCnt == H_W'(H_TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hCnt <= '0;
    else if (!en)      hCnt <= '0;
    else if (lineEnd)  hCnt <= '0;
    else if (unitTick) hCnt <= hCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vCnt <= '0;
    else if (!en) vCnt <= '0;
    else if (lineEnd) begin
      if (vCnt == V_W'(V_TOTAL - 1)) vCnt <= '0;
      else                           vCnt <= vCnt + 1'b1;
    end
  end

  assign hPos = 16'(hCnt);
  assign vPos = 16'(vCnt);

  assign hbWin = inWin(hPos, {8'h00, cfg.hbStart}, {8'h00, cfg.hbEnd});
  assign hsWin = inWin(hPos, {8'h00, cfg.hsStart}, {8'h00, cfg.hsEnd});
  assign xhWin = inWin(hPos, {8'h00, cfg.xhStart}, {8'h00, cfg.xhEnd});
  assign vbWin = inWin(vPos, cfg.vbStart,          {8'h00, cfg.vbEnd});
  assign vsWin = inWin(vPos, {8'h00, cfg.vsStart}, {8'h00, cfg.vsEnd});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vbQ <= 1'b0;
    else        vbQ <= en && vbWin;
  end

  assign evt.vbRise  = en && vbWin && !vbQ;

  assign hsync       = en && hsWin;
  assign vsync       = en && vsWin;
  assign csync       = hsync ^ (vsync && (hPos < {8'h00, cfg.csEnd}));
  assign blank       = !en || hbWin || vbWin;
  assign pixelActive = en && cfg.videoEn && !hbWin && !vbWin;
  assign xferHoldoff = en && xhWin;

endmodule

// File: rtl/raster_timing.sv
module raster_timing
  import raster_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int PIX_PER_UNIT = 8,
  parameter int H_TOTAL      = 200,
  parameter int V_TOTAL      = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [2:0]        senseIn,
  input  logic [3:0]        monIdIn,
  output logic              hsync,
  output logic              vsync,
  output logic              csync,
  output logic              blank,
  output logic              pixelActive,
  output logic              xferHoldoff,
  output logic              irq
);

  timingCfg_t cfgBus;
  dpEvt_t     evtBus;

  raster_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .senseIn  (senseIn),
    .monIdIn  (monIdIn),
    .evt      (evtBus),
    .cfg      (cfgBus),
    .irq      (irq)
  );

  raster_dp #(
    .PIX_PER_UNIT (PIX_PER_UNIT),
    .H_TOTAL      (H_TOTAL),
    .V_TOTAL      (V_TOTAL)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfgBus),
    .evt         (evtBus),
    .hsync       (hsync),
    .vsync       (vsync),
    .csync       (csync),
    .blank       (blank),
    .pixelActive (pixelActive),
    .xferHoldoff (xferHoldoff)
  );

endmodule

// File: rtl/raster_checker.sv
module raster_checker
  import raster_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input timingCfg_t        cfg,
  input dpEvt_t            evt,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              hsync,
  input logic              vsync,
  input logic              csync,
  input logic              blank,
  input logic              pixelActive,
  input logic              irq
);

  // R4
  timing_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.timingEn |-> (!hsync && !vsync && !csync && blank && !pixelActive));

  // R8
  pixel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pixelActive |-> (!blank && cfg.videoEn));

  // R9
  csync_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |-> (csync == hsync));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt.vbRise && cfg.intEn));

  // R12
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == ADDR_W'(17) && busWdata[7] && !(evt.vbRise && cfg.intEn))
      |=> !irq);

  // R13
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.intEn && !irq) |=> !irq);

endmodule

bind raster_timing raster_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg         (cfgBus),
  .evt         (evtBus),
  .busWr       (busWr),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .hsync       (hsync),
  .vsync       (vsync),
  .csync       (csync),
  .blank       (blank),
  .pixelActive (pixelActive),
  .irq         (irq)
);

// File: tb/sim_raster_timing.sv
`timescale 1ns/1ps
module sim_raster_timing;

  localparam int AW    = 5;
  localparam int P     = 2;
  localparam int HT    = 24;
  localparam int VT    = 20;
  localparam int FRAME = P * HT * VT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0]    busWdata = '0;
  logic [7:0]    busRdata;
  logic [2:0]    senseIn = 3'd4;
  logic [3:0]    monIdIn = 4'd1;
  logic          hsync, vsync, csync, blank, pixelActive, xferHoldoff, irq;

  int  vecs = 0;
  int  errs = 0;
  bit  chkOn = 1'b0;

  always #2.5 clk = ~clk;

  raster_timing #(.ADDR_W(AW), .PIX_PER_UNIT(P), .H_TOTAL(HT), .V_TOTAL(VT)) u0 (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .senseIn(senseIn),
    .monIdIn(monIdIn), .hsync(hsync), .vsync(vsync), .csync(csync),
    .blank(blank), .pixelActive(pixelActive), .xferHoldoff(xferHoldoff),
    .irq(irq)
  );

  // ---------------- reference state from the requirements ----------------
  logic [7:0] mReg [16];
  int         mPs, mH, mV;
  bit         mVbQ, mPend;
  logic [2:0] mSense;
  logic [3:0] mId;

  function automatic bit win(int pos, int s, int e);
    if (s <= e) return (pos >= s) && (pos < e);
    return (pos >= s) || (pos < e);
  endfunction

  function automatic logic [7:0] expRd(int a);
    if (a < 16)  return 8'h00;
    if (a == 17) return {mPend, mSense, mId};
    return mReg[a - 16];
  endfunction

  always @(posedge clk) begin : model
    bit en, vbNow, rise;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mReg[i] = 8'h00;
      mPs = 0; mH = 0; mV = 0; mVbQ = 0; mPend = 0; mSense = 0; mId = 0;
    end else begin
      en    = mReg[0][5];
      vbNow = win(mV, {mReg[9], mReg[10]}, mReg[11]);
      rise  = en && vbNow && !mVbQ;
      if (rise && mReg[0][7]) mPend = 1;
      else if (busWr && busAddr == 17 && busWdata[7]) mPend = 0;
      mVbQ = en && vbNow;
      if (!en) begin
        mPs = 0; mH = 0; mV = 0;
      end else if (mPs == P - 1) begin
        mPs = 0;
        if (mH == HT - 1) begin
          mH = 0;
          mV = (mV == VT - 1) ? 0 : mV + 1;
        end else mH = mH + 1;
      end else mPs = mPs + 1;
      mSense = senseIn;
      mId    = monIdIn;
      if (busWr && busAddr >= 16 && busAddr != 17) mReg[busAddr - 16] = busWdata;
    end
  end

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s got %0h exp %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic checkAll();
    bit en, hb, vb, eHs, eVs, eCs, eBl, ePa, eXh;
    string tg;
    en  = mReg[0][5];
    hb  = win(mH, mReg[4], mReg[5]);
    vb  = win(mV, {mReg[9], mReg[10]}, mReg[11]);
    eHs = en && win(mH, mReg[6], mReg[7]);
    eVs = en && win(mV, mReg[12], mReg[13]);
    eCs = eHs ^ (eVs && (mH < int'(mReg[8])));
    eBl = !en || hb || vb;
    ePa = en && mReg[0][6] && !hb && !vb;
    eXh = en && win(mH, mReg[14], mReg[15]);
    tg  = en ? "" : "R4/";
    chk({tg, "R5"},  "hsync",       8'(hsync),       8'(eHs));
    chk({tg, "R6"},  "vsync",       8'(vsync),       8'(eVs));
    chk({tg, "R9"},  "csync",       8'(csync),       8'(eCs));
    chk({tg, "R7"},  "blank",       8'(blank),       8'(eBl));
    chk({tg, "R8"},  "pixelActive", 8'(pixelActive), 8'(ePa));
    chk({tg, "R10"}, "xferHoldoff", 8'(xferHoldoff), 8'(eXh));
    chk("R11", "irq", 8'(irq), 8'(mPend));
    chk((busAddr == 17) ? "R3" : "R2", "busRdata", busRdata, expRd(int'(busAddr)));
  endtask

  always @(posedge clk) begin
    #1;
    if (chkOn) checkAll();
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = AW'(a); busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 2 * FRAME && !irq; i++) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog R1 got running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int r, idx;
    logic [7:0] d;
    void'($urandom(32'd2024));

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "hsync", 8'(hsync), 8'h0);
    chk("R1", "vsync", 8'(vsync), 8'h0);
    chk("R1", "csync", 8'(csync), 8'h0);
    chk("R1", "blank", 8'(blank), 8'h1);
    chk("R1", "pixelActive", 8'(pixelActive), 8'h0);
    chk("R1", "xferHoldoff", 8'(xferHoldoff), 8'h0);
    chk("R1", "irq", 8'(irq), 8'h0);
    busAddr = AW'(17); #0.5;
    chk("R1", "status", busRdata, 8'h00);
    rst_n = 1'b1;
    chkOn = 1'b1;

    // R1/R2: sweep reads of every offset after reset
    for (int a = 0; a < 32; a++) begin @(negedge clk); busAddr = AW'(a); end

    // baseline setup, control written last
    wr(16'h12, 8'h33); wr(8'h13, 8'h44);
    wr(8'h14, 8'd18);  wr(8'h15, 8'd2);
    wr(8'h16, 8'd19);  wr(8'h17, 8'd21);
    wr(8'h18, 8'd10);
    wr(8'h19, 8'd0);   wr(8'h1A, 8'd16); wr(8'h1B, 8'd2);
    wr(8'h1C, 8'd17);  wr(8'h1D, 8'd19);
    wr(8'h1E, 8'd5);   wr(8'h1F, 8'd9);

    // R2: out-of-map write ignored, then read back
    wr(8'h03, 8'hFF);
    for (int a = 0; a < 32; a++) begin @(negedge clk); busAddr = AW'(a); end

    // R4/R5/R8: timing on, video off, one frame
    wr(8'h10, 8'h20);
    busAddr = AW'(17);
    idle(FRAME + 10);

    // R11: interrupts and video on
    wr(8'h10, 8'hE0);
    idle(FRAME + 10);
    chk("R11", "irq set after a frame", 8'(irq), 8'h1);

    // R12: bit 7 clear has no effect, bit 7 set clears
    waitIrq();
    wr(8'h11, 8'h7F);
    chk("R12", "irq after write 0x7F", 8'(irq), 8'h1);
    wr(8'h11, 8'h80);
    chk("R12", "irq after write 0x80", 8'(irq), 8'h0);

    // R13: interrupts masked for a full frame
    wr(8'h10, 8'h60);
    idle(FRAME + 10);
    chk("R13", "irq masked", 8'(irq), 8'h0);

    // R3: sense pins change, status follows one edge later
    senseIn = 3'd6; monIdIn = 4'd3;
    idle(3);

    // random phase
    for (int it = 0; it < 300; it++) begin
      r = $urandom_range(0, 9);
      if (r <= 3) begin
        for (int k = 0; k < int'($urandom_range(1, 40)); k++) begin
          @(negedge clk); busAddr = AW'($urandom_range(0, 31));
        end
      end else if (r <= 5) begin
        idx = $urandom_range(2, 15);
        if (idx == 9)                     d = ($urandom_range(0, 7) == 0) ? 8'd1 : 8'd0;
        else if (idx >= 10 && idx <= 13)  d = 8'($urandom_range(0, VT + 1));
        else if (idx >= 4)                d = 8'($urandom_range(0, HT + 1));
        else                              d = 8'($urandom_range(0, 255));
        wr(16 + idx, d);
      end else if (r == 6) begin
        d = 8'($urandom_range(0, 255));
        if ($urandom_range(0, 3) != 0) d[5] = 1'b1;
        wr(16, d);
      end else if (r == 7) begin
        wr(17, 8'($urandom_range(0, 255)));
      end else if (r == 8) begin
        @(negedge clk);
        senseIn = 3'($urandom_range(0, 7));
        monIdIn = 4'($urandom_range(0, 15));
      end else begin
        wr($urandom_range(0, 15), 8'($urandom_range(0, 255)));
      end
      idle($urandom_range(1, 20));
    end

    // final readback sweep
    for (int a = 0; a < 32; a++) begin @(negedge clk); busAddr = AW'(a); end
    idle(2);
    chkOn = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule